// File: doc/BRIEF.md
# Fuse Bit Program and Row Read Controller

This block sits between a request source and a one-time-programmable fuse array. It handles two kinds of request, one at a time. A program request names one fuse bit by page, row and column. A read request names a whole row by page and row. Before a bit is set, the controller decides whether the program is allowed. That decision uses a global enable, a sticky lock flag, a fixed map from each row to a lock fuse, and a protected region on page 2. The lock fuses are stored in the same array they protect, so the controller reads the relevant lock fuse first and only then decides.

A read returns the addressed row. Rows that hold keys are blocked: the read returns zero and flags an error. Each request ends with a one-cycle done pulse and, where it applies, an error pulse. These pulses feed a separate interrupt block. A successful program at a high column also refreshes three test-bit status flags from the array's check result.

The controller moves through these states:
- `ST_IDLE` takes a new request. A program request is taken ahead of a read request.
- `ST_PG_LOOK` reads the lock fuse and records whether the program is refused.
- `ST_PG_SET` sets the bit when that is allowed and records the outcome.
- `ST_PG_DONE` pulses the program events and then returns to `ST_IDLE`.
- `ST_RD_ROW` fetches the row and applies the key-row block.
- `ST_RD_DONE` pulses the read events and then returns to `ST_IDLE`.

Top module: `fuse_access_ctrl`

## Requirements
- R1: The program address carries the column in bits 4:0, the row in bits 12:5 and the page in bits 16:13. The read address carries the row in bits 7:0 and the page in bits 11:8. A program sets exactly the addressed bit of the addressed row and page.
- R2: While `prog_en` is 0, every program request is refused and no array bit is set.
- R3: A pulse on `lock_set` sets a sticky flag. While the flag is set, programs to page 0 rows 44 to 51 are refused. Only reset clears the flag.
- R4: On page 0, each row in the following list is refused when its lock fuse reads 1:

  | Page 0 rows | Lock fuse (page 0 row, column) |
  |---|---|
  | 4 | row 4, column 31 |
  | 8–11 | row 43, column 27 |
  | 12–19 | row 43, column 11 |
  | 20–27 | row 43, column 13 |
  | 28–35 | row 43, column 15 |
  | 37 | row 43, column 28 |
  | 64–71 | row 43, column 6 |
  | 72–79 | row 43, column 7 |
  | 80–87 | row 43, column 8 |

- R5: On page 2, addresses from row 129 column 0 through row 255 column 27 are refused when the fuse at page 0, row 43, column 16 reads 1. Other addresses on page 2 are not affected by that fuse.
- R6: The following are never refused by a lock fuse: page 0 rows that are not in the map, pages 1 and 3 to 15, and page 2 addresses outside the region in R5.
- R7: Every program request raises `ev_pgm_done`. `ev_pgm_err` is raised with it when the request was refused or when the array reports `arr_set_ok`=0.
- R8: A read returns the addressed row on `rd_data` and raises `ev_rd_done`. A read of page 0 rows 12 to 35 instead returns zero and also raises `ev_rd_err`.
- R9: A successful program at column 28 or above loads `tbit_status` from `tbit_check`. A program to any other column, and any failed program, leaves `tbit_status` unchanged.
- R10: `busy` is high from the cycle after a request is accepted until the cycle after its done pulse. Requests that arrive while `busy` is high are ignored.
- R11: `ev_pgm_done` is high in the third cycle after the clock edge that accepts the program request. `ev_rd_done` is high in the second cycle after the clock edge that accepts the read request. Each pulse lasts one cycle.
- R12: When a program request and a read request arrive in the same cycle, the program is served and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Global program enable |
| lock_set | input | 1 | Sets the sticky lock flag |
| pgm_req | input | 1 | Program request strobe |
| pgm_addr | input | 17 | Program bit address: page, row, column |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | 12 | Read row address: page, row |
| busy | output | 1 | A request is in service |
| ev_pgm_done | output | 1 | Program finished (one-cycle pulse) |
| ev_pgm_err | output | 1 | Program refused or failed (one-cycle pulse) |
| ev_rd_done | output | 1 | Read finished (one-cycle pulse) |
| ev_rd_err | output | 1 | Read was blocked (one-cycle pulse) |
| rd_data | output | 32 | Last row read |
| tbit_status | output | 3 | Test-bit status flags |
| arr_bit_addr | output | 17 | Array single-bit read address |
| arr_bit_val | input | 1 | Array single-bit read value (same cycle) |
| arr_set_en | output | 1 | Array bit-set strobe |
| arr_set_addr | output | 17 | Array bit-set address |
| arr_set_ok | input | 1 | Array accepted the bit-set (same cycle) |
| arr_row_addr | output | 12 | Array row read address |
| arr_row_data | input | 32 | Array row data (same cycle) |
| tbit_check | input | 3 | Array's test-bit check result |

## Verification
The program events are due exactly three cycles after the accepting edge, and the read events exactly two. The bench samples on the falling edge at those cycles, and it also checks that the done pulse is not yet present in the cycle before. The test-bit flags change on the edge that ends the program-done cycle, so they are checked one falling edge later. Refusals are proven at the ports in two ways: by the error pulse, and by reading the row back afterwards to show that the bit stayed clear.

// File: rtl/fuse_acc_pkg.sv
package fuse_acc_pkg;

    localparam int PAGE_W = 4;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 5;
    localparam int ROWS_W = PAGE_W + ROW_W;
    localparam int BIT_W  = ROWS_W + COL_W;
    localparam int DATA_W = 1 << COL_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PG_LOOK,
        ST_PG_SET,
        ST_PG_DONE,
        ST_RD_ROW,
        ST_RD_DONE
    } fsm_e;

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } lock_ref_t;

    // Lock fuse guarding a target bit; all lock fuses live on page 0.
    function automatic lock_ref_t lock_of(input logic [PAGE_W-1:0] pg,
                                          input logic [ROW_W-1:0]  rw,
                                          input logic [COL_W-1:0]  cl);
        lock_ref_t r;
        r = '{valid: 1'b1, row: 8'd43, col: 5'd0};
        if (pg == 0) begin
            if (rw == 8'd4)                       r = '{1'b1, 8'd4, 5'd31};
            else if (rw >= 8'd8  && rw <= 8'd11)  r.col = 5'd27;
            else if (rw >= 8'd12 && rw <= 8'd19)  r.col = 5'd11;
            else if (rw >= 8'd20 && rw <= 8'd27)  r.col = 5'd13;
            else if (rw >= 8'd28 && rw <= 8'd35)  r.col = 5'd15;
            else if (rw == 8'd37)                 r.col = 5'd28;
            else if (rw >= 8'd64 && rw <= 8'd71)  r.col = 5'd6;
            else if (rw >= 8'd72 && rw <= 8'd79)  r.col = 5'd7;
            else if (rw >= 8'd80 && rw <= 8'd87)  r.col = 5'd8;
            else                                  r.valid = 1'b0;
        end else if (pg == 4'd2 && rw >= 8'd129 && !(rw == 8'd255 && cl > 5'd27)) begin
            r.col = 5'd16;
        end else begin
            r.valid = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/fuse_lock_map.sv
module fuse_lock_map
    import fuse_acc_pkg::*;
(
    input  logic [BIT_W-1:0] tgt_addr,
    input  logic             prog_en,
    input  logic             sticky,
    output logic             hard_refuse,
    output logic             need_fuse,
    output logic [BIT_W-1:0] fuse_addr
);
    logic [PAGE_W-1:0] pg;
    logic [ROW_W-1:0]  rw;
    logic [COL_W-1:0]  cl;
    lock_ref_t         ref_s;

    assign {pg, rw, cl} = tgt_addr;
    assign ref_s        = lock_of(pg, rw, cl);

    always_comb begin
        hard_refuse = !prog_en ||
                      (sticky && pg == '0 && rw >= 8'd44 && rw <= 8'd51);
        need_fuse   = ref_s.valid;
        fuse_addr   = {{PAGE_W{1'b0}}, ref_s.row, ref_s.col};
    end
endmodule

// File: rtl/fuse_read_guard.sv
module fuse_read_guard
    import fuse_acc_pkg::*;
(
    input  logic [ROWS_W-1:0] row_addr,
    input  logic [DATA_W-1:0] row_in,
    output logic              blocked,
    output logic [DATA_W-1:0] row_out
);
    logic [PAGE_W-1:0] pg;
    logic [ROW_W-1:0]  rw;

    assign {pg, rw}  = row_addr;
    assign blocked   = (pg == '0) && (rw >= 8'd12) && (rw <= 8'd35);
    assign row_out   = blocked ? '0 : row_in;
endmodule

// File: rtl/fuse_access_ctrl.sv
module fuse_access_ctrl
    import fuse_acc_pkg::*;
#(
    parameter int TBIT_N   = 3,
    parameter int TBIT_COL = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_en,
    input  logic                lock_set,
    input  logic                pgm_req,
    input  logic [BIT_W-1:0]    pgm_addr,
    input  logic                rd_req,
    input  logic [ROWS_W-1:0]   rd_addr,
    output logic                busy,
    output logic                ev_pgm_done,
    output logic                ev_pgm_err,
    output logic                ev_rd_done,
    output logic                ev_rd_err,
    output logic [DATA_W-1:0]   rd_data,
    output logic [TBIT_N-1:0]   tbit_status,
    output logic [BIT_W-1:0]    arr_bit_addr,
    input  logic                arr_bit_val,
    output logic                arr_set_en,
    output logic [BIT_W-1:0]    arr_set_addr,
    input  logic                arr_set_ok,
    output logic [ROWS_W-1:0]   arr_row_addr,
    input  logic [DATA_W-1:0]   arr_row_data,
    input  logic [TBIT_N-1:0]   tbit_check
);
    fsm_e              st_q, st_d;
    logic [BIT_W-1:0]  pa_q;
    logic [ROWS_W-1:0] ra_q;
    logic              refuse_q, err_q, rblk_q, sticky_q;
    logic [DATA_W-1:0] rdat_q;
    logic [TBIT_N-1:0] tbit_q;

    logic              hard_refuse, need_fuse, rd_blocked;
    logic [BIT_W-1:0]  fuse_addr;
    logic [DATA_W-1:0] row_guarded;

    fuse_lock_map u_lock (
        .tgt_addr    (pa_q),
        .prog_en     (prog_en),
        .sticky      (sticky_q),
        .hard_refuse (hard_refuse),
        .need_fuse   (need_fuse),
        .fuse_addr   (fuse_addr)
    );

    fuse_read_guard u_rguard (
        .row_addr (ra_q),
        .row_in   (arr_row_data),
        .blocked  (rd_blocked),
        .row_out  (row_guarded)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (pgm_req)     st_d = ST_PG_LOOK;
                else if (rd_req) st_d = ST_RD_ROW;
            end
            ST_PG_LOOK: st_d = ST_PG_SET;
            ST_PG_SET:  st_d = ST_PG_DONE;
            ST_PG_DONE: st_d = ST_IDLE;
            ST_RD_ROW:  st_d = ST_RD_DONE;
            ST_RD_DONE: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_q     <= '0;
            ra_q     <= '0;
            refuse_q <= 1'b0;
            err_q    <= 1'b0;
            rblk_q   <= 1'b0;
            rdat_q   <= '0;
            sticky_q <= 1'b0;
            tbit_q   <= '0;
        end else begin
            sticky_q <= sticky_q | lock_set;
            unique case (st_q)
                ST_IDLE: begin
                    if (pgm_req)     pa_q <= pgm_addr;
                    else if (rd_req) ra_q <= rd_addr;
                end
                ST_PG_LOOK: refuse_q <= hard_refuse || (need_fuse && arr_bit_val);
                ST_PG_SET:  err_q    <= refuse_q || !arr_set_ok;
                ST_PG_DONE: begin
                    if (!err_q && pa_q[COL_W-1:0] >= COL_W'(TBIT_COL))
                        tbit_q <= tbit_check;
                end
                ST_RD_ROW: begin
                    rdat_q <= row_guarded;
                    rblk_q <= rd_blocked;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ev_pgm_done  = 1'b0;
        ev_pgm_err   = 1'b0;
        ev_rd_done   = 1'b0;
        ev_rd_err    = 1'b0;
        arr_set_en   = 1'b0;
        arr_bit_addr = fuse_addr;
        arr_set_addr = pa_q;
        arr_row_addr = ra_q;
        unique case (st_q)
            ST_PG_SET:  arr_set_en = !refuse_q;
            ST_PG_DONE: begin
                ev_pgm_done = 1'b1;
                ev_pgm_err  = err_q;
            end
            ST_RD_DONE: begin
                ev_rd_done = 1'b1;
                ev_rd_err  = rblk_q;
            end
            default: ;
        endcase
    end

    assign busy        = (st_q != ST_IDLE);
    assign rd_data     = rdat_q;
    assign tbit_status = tbit_q;
endmodule

// File: rtl/fuse_access_ctrl_chk.sv
module fuse_access_ctrl_chk
    import fuse_acc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              prog_en,
    input logic              busy,
    input logic              ev_pgm_done,
    input logic              ev_pgm_err,
    input logic              ev_rd_done,
    input logic              ev_rd_err,
    input logic [DATA_W-1:0] rd_data,
    input logic              arr_set_en,
    input logic [BIT_W-1:0]  arr_set_addr,
    input logic              sticky_q
);
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pgm_err |-> ev_pgm_done);

    a_r8_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd_err |-> (ev_rd_done && rd_data == '0));

    a_r2_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        arr_set_en |-> $past(prog_en));

    a_r3_sticky_region: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_set_en && arr_set_addr[BIT_W-1 -: PAGE_W] == '0 &&
         arr_set_addr[COL_W +: ROW_W] >= 8'd44 && arr_set_addr[COL_W +: ROW_W] <= 8'd51)
        |-> !$past(sticky_q));

    a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_q |=> sticky_q);

    a_r10_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pgm_done || ev_rd_done) |-> busy);

    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pgm_done || ev_rd_done) |=> !busy);

    a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_pgm_done && ev_rd_done));
endmodule

bind fuse_access_ctrl fuse_access_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_en      (prog_en),
    .busy         (busy),
    .ev_pgm_done  (ev_pgm_done),
    .ev_pgm_err   (ev_pgm_err),
    .ev_rd_done   (ev_rd_done),
    .ev_rd_err    (ev_rd_err),
    .rd_data      (rd_data),
    .arr_set_en   (arr_set_en),
    .arr_set_addr (arr_set_addr),
    .sticky_q     (sticky_q)
);

// File: tb/fuse_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module fuse_access_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en = 1'b0, lock_set = 1'b0;
    logic        pgm_req = 1'b0, rd_req = 1'b0;
    logic [16:0] pgm_addr = '0;
    logic [11:0] rd_addr = '0;
    logic        busy, ev_pgm_done, ev_pgm_err, ev_rd_done, ev_rd_err;
    logic [31:0] rd_data;
    logic [2:0]  tbit_status;
    logic [16:0] arr_bit_addr, arr_set_addr;
    logic        arr_bit_val, arr_set_en, arr_set_ok;
    logic [11:0] arr_row_addr;
    logic [31:0] arr_row_data;
    logic [2:0]  tbit_check = '0;

    int errors = 0;
    int checks = 0;

    // Array model: pages 0..3 only
    logic [31:0] mem [0:1023];
    localparam logic [16:0] STUCK = {4'd1, 8'd7, 5'd9};

    function automatic int idx(input logic [11:0] pr);
        return {pr[9:8], pr[7:0]};
    endfunction

    assign arr_bit_val  = mem[idx(arr_bit_addr[16:5])][arr_bit_addr[4:0]];
    assign arr_row_data = mem[idx(arr_row_addr)];
    assign arr_set_ok   = (arr_set_addr != STUCK);

    always @(posedge clk)
        if (arr_set_en && arr_set_ok)
            mem[idx(arr_set_addr[16:5])][arr_set_addr[4:0]] <= 1'b1;

    always #5 clk = ~clk;

    fuse_access_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .lock_set(lock_set),
        .pgm_req(pgm_req), .pgm_addr(pgm_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .ev_pgm_done(ev_pgm_done), .ev_pgm_err(ev_pgm_err),
        .ev_rd_done(ev_rd_done), .ev_rd_err(ev_rd_err), .rd_data(rd_data),
        .tbit_status(tbit_status), .arr_bit_addr(arr_bit_addr), .arr_bit_val(arr_bit_val),
        .arr_set_en(arr_set_en), .arr_set_addr(arr_set_addr), .arr_set_ok(arr_set_ok),
        .arr_row_addr(arr_row_addr), .arr_row_data(arr_row_data), .tbit_check(tbit_check)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [16:0] ba(input int pg, input int rw, input int cl);
        return {4'(pg), 8'(rw), 5'(cl)};
    endfunction

    task automatic prog(input logic [16:0] a, input logic exp_err, input string tag);
        @(negedge clk); pgm_req = 1'b1; pgm_addr = a;
        @(negedge clk); pgm_req = 1'b0;
        chk(busy, 1, {tag, " R10 busy"});
        @(negedge clk);
        chk(ev_pgm_done, 0, {tag, " R11 early done"});
        @(negedge clk);
        chk(ev_pgm_done, 1, {tag, " R11/R7 done"});
        chk(ev_pgm_err, exp_err, {tag, " R7 err"});
    endtask

    task automatic rdrow(input int pg, input int rw, input logic [31:0] exp_d,
                         input logic exp_err, input string tag);
        @(negedge clk); rd_req = 1'b1; rd_addr = {4'(pg), 8'(rw)};
        @(negedge clk); rd_req = 1'b0;
        chk(ev_rd_done, 0, {tag, " R11 early rd done"});
        @(negedge clk);
        chk(ev_rd_done, 1, {tag, " R11/R8 rd done"});
        chk(ev_rd_err, exp_err, {tag, " R8 rd err"});
        chk(rd_data, exp_d, {tag, " R8 data"});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk(busy, 0, "R10 reset busy");
        chk({ev_pgm_done, ev_pgm_err, ev_rd_done, ev_rd_err}, 0, "R7 reset events");
        chk(rd_data, 0, "R8 reset data");
        chk(tbit_status, 0, "R9 reset tbits");
    endtask

    task automatic t_enable();
        prog_en = 1'b0;
        prog(ba(1, 5, 3), 1'b1, "R2 disabled");
        rdrow(1, 5, 32'h0, 1'b0, "R2 bit stays clear");
        prog_en = 1'b1;
        prog(ba(1, 5, 3), 1'b0, "R1 enabled");
        rdrow(1, 5, 32'h8, 1'b0, "R1 packing");
    endtask

    task automatic t_rowlock();
        prog(ba(0, 9, 0), 1'b0, "R4 before lock");
        prog(ba(0, 43, 27), 1'b0, "R6 unmapped row 43");
        prog(ba(0, 10, 1), 1'b1, "R4 locked row 10");
        rdrow(0, 10, 32'h0, 1'b0, "R4 row 10 clear");
        rdrow(0, 9, 32'h1, 1'b0, "R4 row 9");
        prog(ba(0, 4, 31), 1'b0, "R4 row4 lock fuse");
        prog(ba(0, 4, 2), 1'b1, "R4 row4 locked");
        prog(ba(0, 100, 2), 1'b0, "R6 row 100");
    endtask

    task automatic t_sticky();
        prog(ba(0, 44, 0), 1'b0, "R3 before sticky");
        @(negedge clk); lock_set = 1'b1;
        @(negedge clk); lock_set = 1'b0;
        prog(ba(0, 51, 0), 1'b1, "R3 row 51 refused");
        prog(ba(0, 52, 0), 1'b0, "R3 row 52 free");
        rdrow(0, 51, 32'h0, 1'b0, "R3 row 51 clear");
        prog(ba(1, 45, 0), 1'b0, "R6 page1 row 45");
    endtask

    task automatic t_puf();
        prog(ba(2, 129, 0), 1'b0, "R5 before lock");
        prog(ba(0, 43, 16), 1'b0, "R5 set lock fuse");
        prog(ba(2, 200, 5), 1'b1, "R5 region refused");
        prog(ba(2, 255, 27), 1'b1, "R5 region end");
        prog(ba(2, 255, 28), 1'b0, "R5 past region end");
        prog(ba(2, 128, 31), 1'b0, "R5 before region");
        rdrow(2, 200, 32'h0, 1'b0, "R5 row 200 clear");
    endtask

    task automatic t_arrfail();
        prog(STUCK, 1'b1, "R7 array fail");
    endtask

    task automatic t_keyread();
        prog(ba(0, 12, 0), 1'b0, "R8 key row program");
        rdrow(0, 12, 32'h0, 1'b1, "R8 key row blocked");
        rdrow(0, 35, 32'h0, 1'b1, "R8 key row 35 blocked");
        prog(ba(1, 12, 4), 1'b0, "R8 page1 row12 program");
        rdrow(1, 12, 32'h10, 1'b0, "R8 page1 not blocked");
        rdrow(0, 43, 32'h0801_0000, 1'b0, "R8 lock row read");
    endtask

    task automatic t_tbits();
        tbit_check = 3'b101;
        prog(ba(3, 0, 28), 1'b0, "R9 high column");
        @(negedge clk);
        chk(tbit_status, 3'b101, "R9 refresh");
        tbit_check = 3'b010;
        prog(ba(3, 0, 27), 1'b0, "R9 low column");
        @(negedge clk);
        chk(tbit_status, 3'b101, "R9 low column no refresh");
        prog_en = 1'b0;
        prog(ba(3, 0, 30), 1'b1, "R9 refused");
        @(negedge clk);
        chk(tbit_status, 3'b101, "R9 refused no refresh");
        prog_en = 1'b1;
    endtask

    task automatic t_busy();
        int seen;
        seen = 0;
        @(negedge clk); pgm_req = 1'b1; pgm_addr = ba(1, 60, 1);
        @(negedge clk); pgm_req = 1'b0; rd_req = 1'b1; rd_addr = {4'd1, 8'd5};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) rd_req = 1'b0;
            if (ev_rd_done) seen++;
        end
        chk(seen, 0, "R10 read ignored while busy");
        chk(busy, 0, "R10 idle again");
    endtask

    task automatic t_both();
        int rds;
        rds = 0;
        @(negedge clk); pgm_req = 1'b1; rd_req = 1'b1;
        pgm_addr = ba(1, 61, 2); rd_addr = {4'd1, 8'd5};
        @(negedge clk); pgm_req = 1'b0; rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ev_pgm_done, 1, "R12 program served");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (ev_rd_done) rds++;
        end
        chk(rds, 0, "R12 read dropped");
        rdrow(1, 61, 32'h4, 1'b0, "R12 bit set");
    endtask

    task automatic t_reset_clears();
        do_reset();
        prog(ba(0, 50, 0), 1'b0, "R3 reset clears sticky");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        do_reset();
        t_reset();
        t_enable();
        t_rowlock();
        t_sticky();
        t_puf();
        t_arrfail();
        t_keyread();
        t_tbits();
        t_busy();
        t_both();
        t_reset_clears();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule